// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the raster timing for a display panel. Software programs four counts through a small register port: the line length and its visible part, and the frame height and its visible part. A pair of counters then walks each line in pixel periods and each frame in lines. The outputs are a display-enable, a line-start strobe and a frame-start strobe, together with the current pixel column and line number. Line lengths are programmed in 8-pixel units. Each line and each frame begins with its visible portion, and the blanking part follows.

A two-bit hold field in the control word parks the block. While parked, every panel output is low and the counters stay at zero, but the registers can still be read and written. A write of a horizontal setting that breaks the panel rules sets a sticky error flag, which also parks the outputs until software clears it. New timing values are staged and only take effect at a frame boundary, so a frame never mixes old and new settings.

Top module: `lcd_timing_gen`

## Requirements
- R1: Word address 0 holds the horizontal counts: total count in bits 22:16 and visible count in bits 6:0. Word address 1 holds the vertical counts: total count in bits 25:16 and visible count in bits 9:0. All fields reset to zero, every other bit reads as zero, and read data appears on the clock edge after the address is presented.
- R2: Word address 2 bits 1:0 are the hold field, which resets to 0. Writing 0 parks the block and writing 3 resumes it. Writing 1 or 2 leaves the current mode unchanged, and the written value reads back.
- R3: While parked, panel_de, line_start, frame_start, pix_x and line_y are all zero from the second edge after the parking write. Register writes and reads still work while parked.
- R4: A line lasts (total count + 1) × 8 pixel clocks. pix_x counts up by one from 0 within the line, and line_start is high exactly when pix_x is 0.
- R5: A frame lasts (vertical total count + 1) lines. line_y counts lines from 0, and frame_start is high only at pix_x = 0 and line_y = 0, together with line_start.
- R6: While running, panel_de is high exactly when pix_x < (visible count + 1) × 8 and line_y <= vertical visible count.
- R7: Bit 8 of word 2 is a sticky error flag. It is set by any write to word 0 whose visible field is 0 or whose total field is less than the visible field + 3. A valid write (total = visible + 3 included) leaves it unchanged. A word-2 write with bit 8 set clears it, and that same write also applies bits 1:0. While the flag is set, all panel outputs are held low.
- R8: Writes to words 0 and 1 made while running take effect at the next frame start, and never within the current frame. Values written while parked apply from the restart.
- R9: When running is re-enabled (by a resume write, or by clearing the error with the hold field at 3), frame_start, line_start and panel_de go high with pix_x = line_y = 0 on the second clock edge after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the word addressed on the prior edge |
| panel_de | output | 1 | Display enable |
| line_start | output | 1 | High on the first pixel of every line |
| frame_start | output | 1 | High on the first pixel of every frame |
| pix_x | output | 10 | Current pixel column |
| line_y | output | 10 | Current line number |

## Verification
On every cycle, the assertions check the following:
- both strobes appear only at the origin of their line or frame, and a frame start always opens a visible pixel;
- the column advances by exactly one between line starts, and the line number by exactly one at each new line;
- the outputs are quiet one edge after running is withdrawn;
- reserved bits of the horizontal word read back as zero.

Only the bench scenarios can show the rest:
- the exact line and frame lengths and the visible window for given settings;
- that staged values wait for the frame boundary;
- the error flag's set and clear rules at the total/visible boundary;
- that hold codes 1 and 2 leave the mode unchanged;
- the two-edge restart latency.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_HORZ = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_VERT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  localparam int TOTAL_LSB = 16;
  localparam int ERR_BIT   = 8;

  localparam logic [1:0] HOLD_ENTER = 2'b00;
  localparam logic [1:0] HOLD_LEAVE = 2'b11;

  localparam int MIN_GAP = 3;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int H_CNT_W = 7,
  parameter int V_CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [H_CNT_W-1:0] stg_ht,
  output logic [H_CNT_W-1:0] stg_hd,
  output logic [V_CNT_W-1:0] stg_vt,
  output logic [V_CNT_W-1:0] stg_vd,
  output logic               run_req
);
  localparam int CMP_W = H_CNT_W + 1;

  logic [1:0]       hold_field;
  logic             mode_on;
  logic             cfg_err;
  logic [CMP_W-1:0] w_tot;
  logic [CMP_W-1:0] w_vis;
  logic             w_h_ok;
  logic [31:0]      rd_mux;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    w_tot  = {1'b0, wdata[TOTAL_LSB +: H_CNT_W]};
    w_vis  = {1'b0, wdata[0 +: H_CNT_W]};
    w_h_ok = (w_vis != '0) && (w_tot >= w_vis + CMP_W'(MIN_GAP));
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_HORZ: begin
        rd_mux[TOTAL_LSB +: H_CNT_W] = stg_ht;
        rd_mux[0 +: H_CNT_W]         = stg_hd;
      end
      ADDR_VERT: begin
        rd_mux[TOTAL_LSB +: V_CNT_W] = stg_vt;
        rd_mux[0 +: V_CNT_W]         = stg_vd;
      end
      ADDR_CTRL: begin
        rd_mux[1:0]     = hold_field;
        rd_mux[ERR_BIT] = cfg_err;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      stg_ht     <= '0;
      stg_hd     <= '0;
      stg_vt     <= '0;
      stg_vd     <= '0;
      hold_field <= HOLD_ENTER;
      mode_on    <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      rdata <= rd_mux;
      if (we) begin
        case (addr)
          ADDR_HORZ: begin
            stg_ht <= wdata[TOTAL_LSB +: H_CNT_W];
            stg_hd <= wdata[0 +: H_CNT_W];
            if (!w_h_ok) cfg_err <= 1'b1;
          end
          ADDR_VERT: begin
            stg_vt <= wdata[TOTAL_LSB +: V_CNT_W];
            stg_vd <= wdata[0 +: V_CNT_W];
          end
          ADDR_CTRL: begin
            hold_field <= wdata[1:0];
            if (wdata[1:0] == HOLD_ENTER)      mode_on <= 1'b0;
            else if (wdata[1:0] == HOLD_LEAVE) mode_on <= 1'b1;
            if (wdata[ERR_BIT]) cfg_err <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign run_req = mode_on && !cfg_err;
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan #(
  parameter int H_CNT_W = 7,
  parameter int V_CNT_W = 10,
  parameter int UNIT_LG = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run_req,
  input  logic [H_CNT_W-1:0]         stg_ht,
  input  logic [H_CNT_W-1:0]         stg_hd,
  input  logic [V_CNT_W-1:0]         stg_vt,
  input  logic [V_CNT_W-1:0]         stg_vd,
  output logic                       de,
  output logic                       ls,
  output logic                       fs,
  output logic [H_CNT_W+UNIT_LG-1:0] px,
  output logic [V_CNT_W-1:0]         ly
);
  localparam int XW = H_CNT_W + UNIT_LG;

  logic               act;
  logic [H_CNT_W-1:0] act_ht;
  logic [H_CNT_W-1:0] act_hd;
  logic [V_CNT_W-1:0] act_vt;
  logic [V_CNT_W-1:0] act_vd;
  logic [XW-1:0]      px_nx;
  logic [V_CNT_W-1:0] ly_nx;
  logic               end_line;
  logic               end_frame;

  always_comb begin
    px_nx     = px + XW'(1);
    ly_nx     = ly + V_CNT_W'(1);
    end_line  = (px == {act_ht, {UNIT_LG{1'b1}}});
    end_frame = end_line && (ly == act_vt);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_req) begin
      act    <= 1'b0;
      px     <= '0;
      ly     <= '0;
      de     <= 1'b0;
      ls     <= 1'b0;
      fs     <= 1'b0;
      act_ht <= stg_ht;
      act_hd <= stg_hd;
      act_vt <= stg_vt;
      act_vd <= stg_vd;
    end else if (!act || end_frame) begin
      act    <= 1'b1;
      px     <= '0;
      ly     <= '0;
      de     <= 1'b1;
      ls     <= 1'b1;
      fs     <= 1'b1;
      act_ht <= stg_ht;
      act_hd <= stg_hd;
      act_vt <= stg_vt;
      act_vd <= stg_vd;
    end else if (end_line) begin
      px <= '0;
      ly <= ly_nx;
      de <= (ly_nx <= act_vd);
      ls <= 1'b1;
      fs <= 1'b0;
    end else begin
      px <= px_nx;
      de <= (px_nx[XW-1:UNIT_LG] <= act_hd) && (ly <= act_vd);
      ls <= 1'b0;
      fs <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int H_CNT_W = 7,
  parameter int V_CNT_W = 10,
  parameter int UNIT_LG = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [1:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       panel_de,
  output logic                       line_start,
  output logic                       frame_start,
  output logic [H_CNT_W+UNIT_LG-1:0] pix_x,
  output logic [V_CNT_W-1:0]         line_y
);
  logic [H_CNT_W-1:0] stg_ht;
  logic [H_CNT_W-1:0] stg_hd;
  logic [V_CNT_W-1:0] stg_vt;
  logic [V_CNT_W-1:0] stg_vd;
  logic               run_req;

  lcdt_regs #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .stg_ht(stg_ht), .stg_hd(stg_hd), .stg_vt(stg_vt),
    .stg_vd(stg_vd), .run_req(run_req)
  );

  lcdt_scan #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W), .UNIT_LG(UNIT_LG)) u_scan (
    .clk(clk), .rst(rst), .run_req(run_req), .stg_ht(stg_ht), .stg_hd(stg_hd),
    .stg_vt(stg_vt), .stg_vd(stg_vd), .de(panel_de), .ls(line_start),
    .fs(frame_start), .px(pix_x), .ly(line_y)
  );
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int H_CNT_W = 7,
  parameter int V_CNT_W = 10,
  parameter int UNIT_LG = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       run_req,
  input logic [1:0]                 reg_addr,
  input logic [31:0]                reg_rdata,
  input logic                       panel_de,
  input logic                       line_start,
  input logic                       frame_start,
  input logic [H_CNT_W+UNIT_LG-1:0] pix_x,
  input logic [V_CNT_W-1:0]         line_y
);
  localparam int XW = H_CNT_W + UNIT_LG;

  // R5
  fs_origin_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (pix_x == '0 && line_y == '0 && line_start));

  // R4
  ls_origin_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (pix_x == '0));

  // R4
  px_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + XW'(1)));

  // R5
  ly_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && line_y != '0) |-> (line_y == $past(line_y) + V_CNT_W'(1)));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_req |=> (!panel_de && !line_start && !frame_start && pix_x == '0 && line_y == '0));

  // R6
  fs_visible_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> panel_de);

  // R1
  rd_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == lcdt_pkg::ADDR_HORZ) |->
      ((reg_rdata >> (lcdt_pkg::TOTAL_LSB + H_CNT_W)) == '0 &&
       reg_rdata[lcdt_pkg::TOTAL_LSB-1:H_CNT_W] == '0));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(
  .H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W), .UNIT_LG(UNIT_LG)
) u_chk (
  .clk(clk), .rst(rst), .run_req(run_req), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .panel_de(panel_de), .line_start(line_start),
  .frame_start(frame_start), .pix_x(pix_x), .line_y(line_y)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        de, ls, fs;
  logic [9:0]  px, ly;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .panel_de(de), .line_start(ls), .frame_start(fs),
    .pix_x(px), .line_y(ly)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic check_quiet(input string req, input string what);
    chk(!de && !ls && !fs && px == 0 && ly == 0, req, what,
        {de, ls, fs, px, ly}, 0);
  endtask

  task automatic wait_fs(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (fs) seen = 1;
    end
  endtask

  task automatic line_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ls && n < 5000);
  endtask

  task automatic check_restart(input string tag);
    @(negedge clk);
    chk(fs && ls && de && px == 0 && ly == 0, "R9", tag,
        {fs, ls, de, px, ly}, {3'b111, 20'd0});
  endtask

  // R4 R5 R6: walk one whole frame against the computed raster
  task automatic check_frame(input int htc, input int hdc, input int vtc, input int vdc);
    bit seen;
    wait_fs(seen);
    chk(seen, "R5", "frame start seen", seen, 1);
    for (int y = 0; y <= vtc; y++) begin
      for (int x = 0; x < (htc + 1) * 8; x++) begin
        if (!(x == 0 && y == 0)) @(negedge clk);
        chk(px == x && ls == (x == 0), "R4", "pixel/line strobe", {ls, px}, {(x == 0), 10'(x)});
        chk(ly == y && fs == (x == 0 && y == 0), "R5", "line/frame strobe",
            {fs, ly}, {(x == 0 && y == 0), 10'(y)});
        chk(de == (x < (hdc + 1) * 8 && y <= vdc), "R6", "display enable",
            de, (x < (hdc + 1) * 8 && y <= vdc));
      end
    end
    @(negedge clk);
    chk(fs && px == 0 && ly == 0, "R5", "next frame follows", {fs, px, ly}, {1'b1, 20'd0});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    check_quiet("R3", "outputs after reset");
    rd(2'd0, d); chk(d == 0, "R1", "horizontal word reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R1", "vertical word reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R2", "control word reset", d, 0);
    repeat (20) @(negedge clk);
    check_quiet("R2", "parked after reset");
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'hFF84_FF81);
    rd(2'd0, d); chk(d == 32'h0004_0001, "R1", "horizontal readback", d, 32'h0004_0001);
    wr(2'd1, 32'hFC03_FC01);
    rd(2'd1, d); chk(d == 32'h0003_0001, "R1", "vertical readback", d, 32'h0003_0001);
    rd(2'd2, d); chk(d == 0, "R7", "no error on valid boundary write", d, 0);
  endtask

  task automatic t_run_a;
    wr(2'd2, 32'h3);
    check_restart("resume strobe");
    check_frame(4, 1, 3, 1);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    bit seen;
    wr(2'd2, 32'h1);
    wait_fs(seen);
    chk(seen, "R2", "code 1 keeps running", seen, 1);
    rd(2'd2, d); chk(d == 32'h1, "R2", "code 1 reads back", d, 1);
    wr(2'd2, 32'h0);
    @(negedge clk);
    check_quiet("R3", "parked after code 0");
    wr(2'd2, 32'h2);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 59) check_quiet("R2", "code 2 keeps parked");
    end
    wr(2'd0, 32'h0006_0002);
    rd(2'd0, d); chk(d == 32'h0006_0002, "R3", "write while parked", d, 32'h0006_0002);
    wr(2'd1, 32'h0002_0000);
    rd(2'd1, d); chk(d == 32'h0002_0000, "R3", "vertical write while parked", d, 32'h0002_0000);
    check_quiet("R3", "still quiet after writes");
    wr(2'd2, 32'h3);
    check_restart("resume after park");
    check_frame(6, 2, 2, 0);
  endtask

  task automatic t_defer;
    bit seen;
    int n;
    wait_fs(seen);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h0004_0001);
    do @(negedge clk); while (!ls);
    line_len(n);
    chk(n == 56, "R8", "old line length kept mid-frame", n, 56);
    wait_fs(seen);
    line_len(n);
    chk(n == 40, "R8", "new line length at frame start", n, 40);
  endtask

  task automatic t_err;
    logic [31:0] d;
    bit seen;
    int n;
    wr(2'd0, 32'h0003_0001);
    rd(2'd2, d); chk(d == 32'h103, "R7", "gap too small flagged", d, 32'h103);
    check_quiet("R7", "outputs held on error");
    wr(2'd0, 32'h0004_0000);
    rd(2'd2, d); chk(d[8], "R7", "zero visible flagged", d, 32'h103);
    wr(2'd0, 32'h0004_0001);
    rd(2'd2, d); chk(d == 32'h103, "R7", "flag sticky after valid write", d, 32'h103);
    repeat (10) @(negedge clk);
    check_quiet("R7", "still held while flagged");
    wr(2'd2, 32'h103);
    check_restart("restart after clear");
    rd(2'd2, d); chk(d == 32'h3, "R7", "flag cleared", d, 3);
    wait_fs(seen);
    line_len(n);
    chk(n == 40, "R7", "boundary setting runs", n, 40);
  endtask

  initial begin
    #1ms;
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_run_a();
    t_modes();
    t_defer();
    t_err();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule